// File: doc/BRIEF.md
# I2C Slave Address Receiver and Byte Port

This block is the target side of a two-wire I2C bus with a 7-bit address. It samples the bus clock and data lines through synchronisers and spots START and STOP conditions. After a START it shifts in an address byte and compares that byte with a programmed address. It then receives data bytes and acknowledges them, or sends bytes supplied by software. It drives only the low level on each line, as pull-down enables, so the lines work with open-drain wiring.

Software reaches the block through flags and pulse inputs. It can read the received byte and the buffer-full flag. It can also read an overflow flag, the direction of the last matched address, START and STOP status, the clock-release bit and an interrupt flag. On a read transfer the block holds the clock low after each acknowledged byte. The clock stays low until software supplies the next byte to send.

Top module: `i2c_target_port`

## Requirements
- R1: After reset, with the port enabled and the bus idle, neither line is pulled low and buf_full, ovf, irq, start_flag and stop_flag read 0.
- R2: A START (data falling while the clock is high) sets start_flag and clears stop_flag. A STOP (data rising while the clock is high) sets stop_flag and clears start_flag. The two flags are never set together.
- R3: An address byte whose bits 7:1 differ from own_addr gets no acknowledge (data reads 1 on the ninth clock). It leaves irq, buf_full and rx_byte unchanged, and the later bytes of that transfer are not acknowledged.
- R4: A matching address byte with bit 0 = 0 (write) is acknowledged on the ninth clock when buf_full and ovf are both clear. The whole byte goes into rx_byte, and the block sets buf_full and irq and clears rw_flag.
- R5: Data bytes of a write are sampled on rising clock edges, MSB first. Each one is stored in rx_byte, acknowledged, and sets buf_full and irq.
- R6: A byte that completes while buf_full is set gets no acknowledge. It sets ovf and irq, rx_byte keeps its old value, and the block ignores the bytes that follow until the next START.
- R7: A byte that completes while ovf is set and buf_full is clear also gets no acknowledge, and rx_byte keeps its old value.
- R8: A matching address with bit 0 = 1 (read) is acknowledged and sets rw_flag. After the falling edge of the ninth clock the block pulls the clock low and clears hold_release.
- R9: A tx_load pulse during the hold stores tx_byte and sets hold_release. The block drives bit 7 and releases the clock, then sends the remaining bits MSB first. The data line changes only while the clock is low.
- R10: After each sent byte irq is set. If the master acknowledges, the clock is held low again. If the master does not acknowledge, the clock stays released and the block ignores further clocks until a START.
- R11: While enable is low, both lines are released, start_flag and stop_flag read 0, and any transfer in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Port enable |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| scl_pull | output | 1 | Pull the clock line low |
| sda_pull | output | 1 | Pull the data line low |
| own_addr | input | 7 | Address this target answers to |
| tx_load | input | 1 | Pulse: take tx_byte and release the clock hold |
| tx_byte | input | 8 | Byte to send on a read |
| rx_take | input | 1 | Pulse: software has read rx_byte, clears buf_full |
| irq_clr | input | 1 | Pulse: clears irq |
| ovf_clr | input | 1 | Pulse: clears ovf |
| rx_byte | output | 8 | Last accepted address or data byte |
| buf_full | output | 1 | rx_byte holds an unread byte |
| ovf | output | 1 | A byte arrived while the buffer was occupied |
| rw_flag | output | 1 | Direction bit of the last matched address |
| start_flag | output | 1 | START seen most recently |
| stop_flag | output | 1 | STOP seen most recently |
| hold_release | output | 1 | Clock hold released by software |
| irq | output | 1 | Set once per transferred byte |

## Verification
The bench uses the default parameters: a 7-bit address, 8-bit bytes and two synchroniser stages. With two stages the block reacts to a clock edge about three cycles after the edge. The bench master therefore spaces its line changes eight cycles apart. That spacing lets it check clock stretching, ninth-clock acknowledges and data changes on low clock without racing the synchronisers. Directed transfers cover mismatch, overflow with the buffer full, overflow alone, reads ending in acknowledge and in no-acknowledge, and disable during a hold. Random write transfers against a bench model then mix matching and non-matching addresses with random buffer reads.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_ACK,
    ST_HOLD,
    ST_TX,
    ST_TXACK
  } i2cs_state_t;
endpackage

// File: rtl/i2cs_linesync.sv
module i2cs_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cs_busevt.sv
module i2cs_busevt (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_d;
  assign scl_fall  = ~scl & scl_d;
  assign bus_start = scl & scl_d & sda_d & ~sda;
  assign bus_stop  = scl & scl_d & ~sda_d & sda;
endmodule

// File: rtl/i2c_target_port.sv
module i2c_target_port
  import i2cs_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              tx_load,
  input  logic [ADDR_W:0]   tx_byte,
  input  logic              rx_take,
  input  logic              irq_clr,
  input  logic              ovf_clr,
  output logic [ADDR_W:0]   rx_byte,
  output logic              buf_full,
  output logic              ovf,
  output logic              rw_flag,
  output logic              start_flag,
  output logic              stop_flag,
  output logic              hold_release,
  output logic              irq
);
  localparam int DATA_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

  // line synchronisers, one per bus line
  logic [1:0] line_raw, line_s;
  assign line_raw = {sda_in, scl_in};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    i2cs_linesync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(line_raw[g]), .q(line_s[g])
    );
  end

  logic scl_s, sda_s;
  assign scl_s = line_s[0];
  assign sda_s = line_s[1];

  logic scl_rise, scl_fall, bus_start, bus_stop;
  i2cs_busevt u_evt (
    .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2cs_state_t       state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] sh_q, sh_n, txsh_q, txsh_n, buf_q, buf_n;
  logic full_q, full_n, ovf_q, ovf_n, rw_q, rw_n, sta_q, sta_n, sto_q, sto_n;
  logic rel_q, rel_n, irq_q, irq_n, sdao_q, sdao_n, sclo_q, sclo_n;
  logic acked_q, acked_n, mack_q, mack_n;
  logic addr_hit;

  assign addr_hit = (sh_q[DATA_W-1:1] == own_addr);

  always_comb begin
    state_n = state_q; cnt_n = cnt_q; sh_n = sh_q; txsh_n = txsh_q;
    buf_n = buf_q; full_n = full_q; ovf_n = ovf_q; rw_n = rw_q;
    sta_n = sta_q; sto_n = sto_q; rel_n = rel_q; irq_n = irq_q;
    sdao_n = sdao_q; sclo_n = sclo_q; acked_n = acked_q; mack_n = mack_q;

    if (rx_take) full_n = 1'b0;
    if (ovf_clr) ovf_n  = 1'b0;
    if (irq_clr) irq_n  = 1'b0;
    if (tx_load) begin
      txsh_n = tx_byte;
      rel_n  = 1'b1;
    end

    if (!enable) begin
      state_n = ST_IDLE; sta_n = 1'b0; sto_n = 1'b0;
      sdao_n = 1'b0; sclo_n = 1'b0;
    end else if (bus_start) begin
      state_n = ST_ADDR; cnt_n = '0; sta_n = 1'b1; sto_n = 1'b0;
      sdao_n = 1'b0; sclo_n = 1'b0;
    end else if (bus_stop) begin
      state_n = ST_IDLE; sta_n = 1'b0; sto_n = 1'b1;
      sdao_n = 1'b0; sclo_n = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise && cnt_q != FULL_CNT) begin
            sh_n  = {sh_q[DATA_W-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
          end
          if (scl_fall && cnt_q == FULL_CNT) begin
            if (state_q == ST_ADDR && !addr_hit) begin
              state_n = ST_IDLE;
            end else begin
              irq_n   = 1'b1;
              state_n = ST_ACK;
              if (state_q == ST_ADDR) rw_n = sh_q[0];
              if (full_q || ovf_q) begin
                ovf_n   = 1'b1;
                acked_n = 1'b0;
              end else begin
                buf_n   = sh_q;
                full_n  = 1'b1;
                acked_n = 1'b1;
                sdao_n  = 1'b1;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            sdao_n = 1'b0;
            cnt_n  = '0;
            if (!acked_q) begin
              state_n = ST_IDLE;
            end else if (rw_q) begin
              sclo_n  = 1'b1;
              rel_n   = 1'b0;
              state_n = ST_HOLD;
            end else begin
              state_n = ST_RX;
            end
          end
        end
        ST_HOLD: begin
          if (tx_load) begin
            sclo_n  = 1'b0;
            sdao_n  = ~tx_byte[DATA_W-1];
            cnt_n   = '0;
            state_n = ST_TX;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              sdao_n  = 1'b0;
              state_n = ST_TXACK;
            end else begin
              txsh_n = {txsh_q[DATA_W-2:0], txsh_q[DATA_W-1]};
              sdao_n = ~txsh_q[DATA_W-2];
              cnt_n  = cnt_q + 1'b1;
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) mack_n = ~sda_s;
          if (scl_fall) begin
            irq_n = 1'b1;
            if (mack_q) begin
              sclo_n  = 1'b1;
              rel_n   = 1'b0;
              state_n = ST_HOLD;
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; txsh_q <= '0; buf_q <= '0;
      full_q <= 1'b0; ovf_q <= 1'b0; rw_q <= 1'b0; sta_q <= 1'b0; sto_q <= 1'b0;
      rel_q <= 1'b1; irq_q <= 1'b0; sdao_q <= 1'b0; sclo_q <= 1'b0;
      acked_q <= 1'b0; mack_q <= 1'b0;
    end else begin
      state_q <= state_n; cnt_q <= cnt_n; sh_q <= sh_n; txsh_q <= txsh_n; buf_q <= buf_n;
      full_q <= full_n; ovf_q <= ovf_n; rw_q <= rw_n; sta_q <= sta_n; sto_q <= sto_n;
      rel_q <= rel_n; irq_q <= irq_n; sdao_q <= sdao_n; sclo_q <= sclo_n;
      acked_q <= acked_n; mack_q <= mack_n;
    end
  end

  assign scl_pull     = sclo_q;
  assign sda_pull     = sdao_q;
  assign rx_byte      = buf_q;
  assign buf_full     = full_q;
  assign ovf          = ovf_q;
  assign rw_flag      = rw_q;
  assign start_flag   = sta_q;
  assign stop_flag    = sto_q;
  assign hold_release = rel_q;
  assign irq          = irq_q;

  // R2: START and STOP status are exclusive
  p_flags_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_flag && stop_flag));

  // R6: a rising overflow never coincides with a buffer update
  p_ovf_keeps_buf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $stable(rx_byte));

  // R8: the clock is only stretched on a read, with the release bit clear
  p_hold_only_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull |-> (rw_flag && !hold_release));

  // R9: the data drive changes only after a cycle with the clock seen low
  p_sda_on_low_scl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && (sda_pull != $past(sda_pull))) |-> !$past(scl_s));

  // R11: disabling releases both lines and clears the bus status
  p_disable_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!start_flag && !stop_flag && !scl_pull && !sda_pull));
endmodule

// File: tb/i2c_target_port_bench.sv
module i2c_target_port_bench;
  localparam int Q = 8;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, enable, tx_load, rx_take, irq_clr, ovf_clr;
  logic [7:0] tx_byte, rx_byte;
  logic scl_pull, sda_pull, buf_full, ovf, rw_flag, start_flag, stop_flag, hold_release, irq;
  logic m_scl, m_sda, scl_bus, sda_bus;
  logic [6:0] own_addr;

  assign scl_bus = m_scl & ~scl_pull;
  assign sda_bus = m_sda & ~sda_pull;

  i2c_target_port u_i2c_target_port (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .own_addr(own_addr),
    .tx_load(tx_load), .tx_byte(tx_byte), .rx_take(rx_take), .irq_clr(irq_clr),
    .ovf_clr(ovf_clr), .rx_byte(rx_byte), .buf_full(buf_full), .ovf(ovf),
    .rw_flag(rw_flag), .start_flag(start_flag), .stop_flag(stop_flag),
    .hold_release(hold_release), .irq(irq)
  );

  int vecs = 0, errs = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_nack(input logic live, input logic full, input logic ov);
    return !(live && !full && !ov);
  endfunction

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic m_bit(input logic b, output logic r);
    m_sda = b; wq(Q);
    m_scl = 1'b1; wait_scl_high(); wq(Q);
    r = sda_bus; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic m_start();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wait_scl_high(); wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wait_scl_high(); wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic m_write(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(d[i], r);
    m_bit(1'b1, ack);
  endtask

  task automatic m_read(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, r);
      d[i] = r;
    end
    m_bit(mack, r);
  endtask

  task automatic pulse_take();  rx_take = 1'b1; @(negedge clk); rx_take = 1'b0; endtask
  task automatic pulse_oclr();  ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0; endtask
  task automatic pulse_iclr();  irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0; endtask
  task automatic load_tx(input logic [7:0] b);
    tx_byte = b; tx_load = 1'b1; @(negedge clk); tx_load = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vecs++; errs++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic ack, mfull, movf, live;
    logic [7:0] d, rd, mbuf, first;
    logic [6:0] a;
    int n;
    void'($urandom(32'd1234));
    rst_n = 1'b0; enable = 1'b0; tx_load = 1'b0; rx_take = 1'b0; irq_clr = 1'b0;
    ovf_clr = 1'b0; tx_byte = '0; m_scl = 1'b1; m_sda = 1'b1; own_addr = OWN;
    wq(4); rst_n = 1'b1; enable = 1'b1; wq(4);

    // R1 reset state
    chk("R1 scl_pull", scl_pull, 0); chk("R1 sda_pull", sda_pull, 0);
    chk("R1 buf_full", buf_full, 0); chk("R1 ovf", ovf, 0); chk("R1 irq", irq, 0);
    chk("R1 start/stop", {start_flag, stop_flag}, 0);

    // R2 / R3: mismatching address
    m_start();
    chk("R2 start_flag", {start_flag, stop_flag}, 2'b10);
    m_write({OWN ^ 7'h01, 1'b0}, ack);
    chk("R3 nack on mismatch", ack, 1);
    chk("R3 irq untouched", irq, 0); chk("R3 buf_full untouched", buf_full, 0);
    chk("R3 rx_byte untouched", rx_byte, 0);
    m_write(8'h5C, ack);
    chk("R3 later byte ignored", ack, 1);
    m_stop();
    chk("R2 stop_flag", {start_flag, stop_flag}, 2'b01);

    // R4 / R5 / R6 / R7: write transfer
    m_start();
    m_write({OWN, 1'b0}, ack);
    chk("R4 ack on match", ack, 0); chk("R4 rx_byte addr", rx_byte, {OWN, 1'b0});
    chk("R4 buf_full", buf_full, 1); chk("R4 irq", irq, 1); chk("R4 rw_flag", rw_flag, 0);
    pulse_iclr(); pulse_take();
    m_write(8'hB3, ack);
    chk("R5 ack data", ack, 0); chk("R5 rx_byte", rx_byte, 8'hB3);
    chk("R5 buf_full", buf_full, 1); chk("R5 irq", irq, 1);
    pulse_iclr();
    m_write(8'h47, ack);
    chk("R6 nack when full", ack, 1); chk("R6 ovf", ovf, 1);
    chk("R6 rx_byte kept", rx_byte, 8'hB3); chk("R6 irq", irq, 1);
    m_write(8'h11, ack);
    chk("R6 later byte ignored", ack, 1);
    m_stop();
    pulse_take();
    m_start();
    m_write({OWN, 1'b0}, ack);
    chk("R7 nack while ovf set", ack, 1); chk("R7 rx_byte kept", rx_byte, 8'hB3);
    m_stop();
    pulse_oclr(); pulse_iclr();

    // R8 / R9 / R10: read transfer
    m_start();
    m_write({OWN, 1'b1}, ack);
    chk("R8 ack read addr", ack, 0); chk("R8 rw_flag", rw_flag, 1);
    chk("R8 scl held", scl_pull, 1); chk("R8 hold_release", hold_release, 0);
    pulse_take(); pulse_iclr();
    load_tx(8'hA5); wq(2);
    chk("R9 hold_release", hold_release, 1); chk("R9 scl released", scl_pull, 0);
    m_read(1'b0, rd);
    chk("R9 data msb first", rd, 8'hA5);
    chk("R10 held after ack", scl_pull, 1); chk("R10 irq", irq, 1);
    pulse_iclr();
    first = 8'($urandom);
    load_tx(first);
    m_read(1'b1, rd);
    chk("R9 second byte", rd, first);
    chk("R10 released after nack", scl_pull, 0); chk("R10 irq nack", irq, 1);
    m_write(8'h00, ack);
    chk("R10 idle after nack", ack, 1);
    m_stop();

    // R11: disable during a hold
    pulse_iclr();
    m_start();
    m_write({OWN, 1'b1}, ack);
    chk("R11 pre hold", scl_pull, 1);
    enable = 1'b0; wq(2);
    chk("R11 scl released", scl_pull, 0); chk("R11 sda released", sda_pull, 0);
    chk("R11 flags cleared", {start_flag, stop_flag}, 0);
    enable = 1'b1; wq(2);
    m_stop();
    pulse_take(); pulse_oclr(); pulse_iclr();

    // random write transfers checked against a bench model
    for (int it = 0; it < 16; it++) begin
      pulse_take(); pulse_oclr(); pulse_iclr();
      mfull = 1'b0; movf = 1'b0;
      a = 7'($urandom);
      if ($urandom % 2) a = OWN;
      else if (a == OWN) a = a ^ 7'h01;
      live = (a == OWN);
      m_start();
      m_write({a, 1'b0}, ack);
      chk("R3/R4 random addr ack", ack, exp_nack(live, mfull, movf));
      if (live) begin mfull = 1'b1; mbuf = {a, 1'b0}; end
      n = 1 + ($urandom % 3);
      for (int k = 0; k < n; k++) begin
        d = 8'($urandom);
        if ($urandom % 2) begin pulse_take(); mfull = 1'b0; end
        m_write(d, ack);
        chk("R5/R6/R7 random data ack", ack, exp_nack(live, mfull, movf));
        if (live) begin
          if (mfull || movf) begin movf = 1'b1; live = 1'b0; end
          else begin mbuf = d; mfull = 1'b1; end
        end
        if (a == OWN) begin
          chk("R5/R6 random rx_byte", rx_byte, mbuf);
          chk("R6 random ovf", ovf, movf);
        end
      end
      m_stop();
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule